// File: doc/BRIEF.md
# Dual-Speed Single-Wire Bus Master

This block drives the physical layer of an open-drain single-wire bus. A host hands it one command at a time: a bus reset with presence detection, a single write bit, or a single read bit. The block turns the command into a precisely timed low pulse on the bus, samples the bus at a fixed point, and returns a one-bit result. The host selects standard or overdrive timing per command. Assembling bytes, least significant bit first, is the host's job.

All timing is counted in microseconds. A prescaler divides the system clock by `CLK_MHZ` to make a one-microsecond tick, and both the prescaler and the microsecond counter restart when a command is accepted. Each timing point below is therefore an exact number of clock cycles after the accepting edge, namely microseconds times `CLK_MHZ`. The bus output is a drive-low enable for an external open-drain pad. The bus input passes through a two-flop synchronizer before it is sampled.

Top module: `swire_master`

## Requirements
- R1: After reset, `cmd_ready` is 1, `bus_drive_low` is 0 and `resp_valid` is 0.
- R2: A command is taken only on a clock edge where `cmd_valid` and `cmd_ready` are both 1. `cmd_ready` stays 0 from the accepting edge until the result is returned, and a command offered in that interval is ignored and starts nothing.
- R3: Standard-speed reset: `bus_drive_low` is held for 500 us and the operation lasts 980 us in total. `resp_bit` is 1 (presence) exactly when the sensed bus is low 570 us after acceptance, which is 70 us after release.
- R4: Overdrive reset: `bus_drive_low` is held for 64 us and the operation lasts 112 us in total. Presence is sampled 73 us after acceptance.
- R5: Standard-speed write: a 0 bit holds `bus_drive_low` for 60 us and a 1 bit holds it for 6 us. The whole slot lasts 70 us.
- R6: Overdrive write: a 0 bit holds `bus_drive_low` for 8 us and a 1 bit holds it for 1 us. The whole slot lasts 10 us.
- R7: Read: `bus_drive_low` is held for 6 us (standard) or 1 us (overdrive), and the slot lasts 70 us or 10 us. `resp_bit` equals the sensed bus level 15 us (standard) or 2 us (overdrive) after acceptance.
- R8: `cmd_op` encodes the operation as follows: 2'b00 is reset, 2'b01 is write of `cmd_bit`, and 2'b10 and 2'b11 are both read.
- R9: `od_sel` (1 = overdrive) is captured at acceptance. Changing it during an operation does not alter that operation's timing.
- R10: `resp_valid` is a single-cycle pulse in the first cycle after the operation's last microsecond. In that cycle `cmd_ready` is already 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, `CLK_MHZ` MHz |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Host offers a command |
| cmd_ready | output | 1 | Block is idle and will take a command |
| cmd_op | input | 2 | Operation: 00 reset, 01 write, 1x read |
| cmd_bit | input | 1 | Bit value for a write |
| od_sel | input | 1 | 1 selects overdrive timing |
| bus_in | input | 1 | Raw sensed bus level (asynchronous) |
| bus_drive_low | output | 1 | 1 pulls the bus low |
| resp_valid | output | 1 | One-cycle pulse: operation finished |
| resp_bit | output | 1 | Presence (reset) or sampled bus level (read/write) |

## Verification
The assertions assume a host that offers commands with `cmd_op` and `cmd_bit` settled, and a bus that only goes low while the block or an emulated slave pulls it. They make no assumption about the level of `bus_in` at a sample point. The bench's slave model answers a long low pulse with a presence pulse whose window brackets the sample point. On a zero read it holds the bus low well past the sample. All of its transitions fall many microseconds away from any sample or release, so the synchronizer delay cannot move a result. Every command is offered on a falling clock edge. Only commands offered while busy are deliberately left pending across a rising edge.

// File: rtl/swire_master.sv
`timescale 1ns/1ps
module swire_master #(
  parameter int CLK_MHZ      = 125,
  parameter int STD_RST_LOW  = 500,
  parameter int STD_RST_SAMP = 570,
  parameter int STD_RST_TOT  = 980,
  parameter int STD_W0_LOW   = 60,
  parameter int STD_W1_LOW   = 6,
  parameter int STD_BIT_SAMP = 15,
  parameter int STD_SLOT     = 70,
  parameter int OD_RST_LOW   = 64,
  parameter int OD_RST_SAMP  = 73,
  parameter int OD_RST_TOT   = 112,
  parameter int OD_W0_LOW    = 8,
  parameter int OD_W1_LOW    = 1,
  parameter int OD_BIT_SAMP  = 2,
  parameter int OD_SLOT      = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  input  logic [1:0] cmd_op,
  input  logic       cmd_bit,
  input  logic       od_sel,
  input  logic       bus_in,
  output logic       bus_drive_low,
  output logic       resp_valid,
  output logic       resp_bit
);
  localparam int PW = (CLK_MHZ > 1) ? $clog2(CLK_MHZ) : 1;
  localparam int UW = $clog2(STD_RST_TOT + 1);

  logic          busy, od_q, bit_q, s1, s2, smp;
  logic [1:0]    op_q;
  logic [PW-1:0] pre;
  logic [UW-1:0] us, low_len, samp_at, tot;
  logic          tick, is_rst, is_w0;

  assign cmd_ready = !busy;
  assign tick      = busy && (pre == PW'(CLK_MHZ - 1));
  assign is_rst    = (op_q == 2'b00);
  assign is_w0     = (op_q == 2'b01) && !bit_q;

  always_comb begin
    if (is_rst) begin
      low_len = od_q ? UW'(OD_RST_LOW)  : UW'(STD_RST_LOW);
      samp_at = od_q ? UW'(OD_RST_SAMP) : UW'(STD_RST_SAMP);
      tot     = od_q ? UW'(OD_RST_TOT)  : UW'(STD_RST_TOT);
    end else begin
      if (is_w0) low_len = od_q ? UW'(OD_W0_LOW) : UW'(STD_W0_LOW);
      else       low_len = od_q ? UW'(OD_W1_LOW) : UW'(STD_W1_LOW);
      samp_at = od_q ? UW'(OD_BIT_SAMP) : UW'(STD_BIT_SAMP);
      tot     = od_q ? UW'(OD_SLOT)     : UW'(STD_SLOT);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; od_q <= 1'b0; bit_q <= 1'b0; op_q <= 2'b00;
      pre <= '0; us <= '0; s1 <= 1'b1; s2 <= 1'b1; smp <= 1'b1;
      bus_drive_low <= 1'b0; resp_valid <= 1'b0; resp_bit <= 1'b0;
    end else begin
      s1 <= bus_in;
      s2 <= s1;
      resp_valid <= 1'b0;
      if (!busy) begin
        if (cmd_valid) begin
          busy <= 1'b1; op_q <= cmd_op; bit_q <= cmd_bit; od_q <= od_sel;
          pre <= '0; us <= '0; bus_drive_low <= 1'b1;
        end
      end else begin
        pre <= tick ? '0 : pre + PW'(1);
        if (tick) begin
          us <= us + UW'(1);
          if (us == low_len - UW'(1)) bus_drive_low <= 1'b0;
          if (us == samp_at - UW'(1)) smp <= s2;
          if (us == tot - UW'(1)) begin
            busy       <= 1'b0;
            resp_valid <= 1'b1;
            resp_bit   <= is_rst ? !smp : smp;
          end
        end
      end
    end
  end

  // R2
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !bus_drive_low || resp_valid == 1'b0 && !bus_drive_low);
  // R2
  accept_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (bus_drive_low && !cmd_ready));
  // R2
  rise_needs_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_drive_low) |-> $past(cmd_valid));
  // R10
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);
  // R10
  done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> (cmd_ready && !bus_drive_low));
  // R3
  release_in_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_drive_low) |-> !cmd_ready);
endmodule

// File: tb/swire_master_bench.sv
`timescale 1ns/1ps
module swire_master_bench;
  localparam int M     = 8;
  localparam int US_NS = M * 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_bit = 1'b0, od_sel = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic cmd_ready, drv, resp_valid, resp_bit;
  logic slave_low = 1'b0;
  logic presence_en = 1'b0, read_zero = 1'b0, od_mode = 1'b0;
  int checks = 0, failures = 0;
  time t0;

  always #4 clk = !clk;

  swire_master #(.CLK_MHZ(M)) u_swire_master (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_bit(cmd_bit), .od_sel(od_sel),
    .bus_in(!(drv || slave_low)), .bus_drive_low(drv),
    .resp_valid(resp_valid), .resp_bit(resp_bit));

  initial begin
    forever begin
      @(posedge drv);
      t0 = $time;
      if (read_zero) begin
        slave_low = 1'b1;
        #((od_mode ? 4 : 30) * US_NS);
        slave_low = 1'b0;
      end
      wait (!drv);
      if (presence_en && ($time - t0) >= (od_mode ? 40 : 400) * US_NS) begin
        #((od_mode ? 3 : 30) * US_NS);
        slave_low = 1'b1;
        #((od_mode ? 16 : 120) * US_NS);
        slave_low = 1'b0;
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] op, input logic b, input logic od, input logic flip,
                        output int lowc, output int busyc, output int rb,
                        output int rdy_bad, output int rdy_end, output int rv_next);
    @(negedge clk);
    cmd_op = op; cmd_bit = b; od_sel = od; od_mode = od; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    lowc = 0; busyc = 0; rdy_bad = 0;
    while (!resp_valid) begin
      if (drv) lowc++;
      if (cmd_ready) rdy_bad++;
      busyc++;
      if (flip && busyc == 10) od_sel = !od;
      @(negedge clk);
    end
    rb = int'(resp_bit);
    rdy_end = int'(cmd_ready);
    od_sel = od;
    @(negedge clk);
    rv_next = int'(resp_valid);
  endtask

  int lc, bc, rb, rbad, rend, rvn;

  task automatic t_reset_state;
    check("R1 cmd_ready", int'(cmd_ready), 1);
    check("R1 bus_drive_low", int'(drv), 0);
    check("R1 resp_valid", int'(resp_valid), 0);
  endtask

  task automatic t_std_reset;
    presence_en = 1'b1; read_zero = 1'b0;
    run_op(2'b00, 1'b0, 1'b0, 1'b0, lc, bc, rb, rbad, rend, rvn);
    check("R3 low cycles", lc, 500 * M);
    check("R3 total cycles", bc, 980 * M);
    check("R3 presence", rb, 1);
    check("R2 ready low while busy", rbad, 0);
    check("R10 ready at done", rend, 1);
    check("R10 single pulse", rvn, 0);
    presence_en = 1'b0;
    run_op(2'b00, 1'b0, 1'b0, 1'b0, lc, bc, rb, rbad, rend, rvn);
    check("R3 no presence", rb, 0);
  endtask

  task automatic t_od_reset;
    presence_en = 1'b1; read_zero = 1'b0;
    run_op(2'b00, 1'b0, 1'b1, 1'b0, lc, bc, rb, rbad, rend, rvn);
    check("R4 low cycles", lc, 64 * M);
    check("R4 total cycles", bc, 112 * M);
    check("R4 presence", rb, 1);
    presence_en = 1'b0;
    run_op(2'b00, 1'b0, 1'b1, 1'b0, lc, bc, rb, rbad, rend, rvn);
    check("R4 no presence", rb, 0);
  endtask

  task automatic t_std_write;
    presence_en = 1'b0; read_zero = 1'b0;
    run_op(2'b01, 1'b0, 1'b0, 1'b0, lc, bc, rb, rbad, rend, rvn);
    check("R5 write0 low", lc, 60 * M);
    check("R5 write0 slot", bc, 70 * M);
    run_op(2'b01, 1'b1, 1'b0, 1'b0, lc, bc, rb, rbad, rend, rvn);
    check("R5 write1 low", lc, 6 * M);
    check("R5 write1 slot", bc, 70 * M);
  endtask

  task automatic t_od_write;
    presence_en = 1'b0; read_zero = 1'b0;
    run_op(2'b01, 1'b0, 1'b1, 1'b0, lc, bc, rb, rbad, rend, rvn);
    check("R6 write0 low", lc, 8 * M);
    check("R6 write0 slot", bc, 10 * M);
    run_op(2'b01, 1'b1, 1'b1, 1'b0, lc, bc, rb, rbad, rend, rvn);
    check("R6 write1 low", lc, 1 * M);
    check("R6 write1 slot", bc, 10 * M);
  endtask

  task automatic t_reads;
    presence_en = 1'b0;
    read_zero = 1'b1;
    run_op(2'b10, 1'b1, 1'b0, 1'b0, lc, bc, rb, rbad, rend, rvn);
    check("R7 std read0 low", lc, 6 * M);
    check("R7 std read0 slot", bc, 70 * M);
    check("R7 std read0 bit", rb, 0);
    run_op(2'b11, 1'b1, 1'b1, 1'b0, lc, bc, rb, rbad, rend, rvn);
    check("R8 op 11 reads, od read0 low", lc, 1 * M);
    check("R7 od read0 slot", bc, 10 * M);
    check("R7 od read0 bit", rb, 0);
    read_zero = 1'b0;
    run_op(2'b10, 1'b0, 1'b0, 1'b0, lc, bc, rb, rbad, rend, rvn);
    check("R8 op 10 ignores cmd_bit, read1 low", lc, 6 * M);
    check("R7 std read1 bit", rb, 1);
    run_op(2'b10, 1'b0, 1'b1, 1'b0, lc, bc, rb, rbad, rend, rvn);
    check("R7 od read1 bit", rb, 1);
  endtask

  task automatic t_speed_latch;
    presence_en = 1'b0; read_zero = 1'b0;
    run_op(2'b01, 1'b0, 1'b0, 1'b1, lc, bc, rb, rbad, rend, rvn);
    check("R9 std write0 low despite od_sel change", lc, 60 * M);
    check("R9 std slot despite od_sel change", bc, 70 * M);
    run_op(2'b01, 1'b0, 1'b1, 1'b1, lc, bc, rb, rbad, rend, rvn);
    check("R9 od write0 low despite od_sel change", lc, 8 * M);
    check("R9 od slot despite od_sel change", bc, 10 * M);
  endtask

  task automatic t_busy_ignore;
    int low_c, busy_c, extra;
    presence_en = 1'b0; read_zero = 1'b0;
    @(negedge clk);
    cmd_op = 2'b01; cmd_bit = 1'b1; od_sel = 1'b0; od_mode = 1'b0; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    low_c = 0; busy_c = 0;
    while (!resp_valid) begin
      if (drv) low_c++;
      busy_c++;
      if (busy_c == 20) begin cmd_op = 2'b00; cmd_valid = 1'b1; end
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    check("R2 slot unaffected low", low_c, 6 * M);
    check("R2 slot unaffected length", busy_c, 70 * M);
    extra = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (drv || !cmd_ready) extra++;
    end
    check("R2 offered-while-busy command not started", extra, 0);
  endtask

  initial begin
    #(200000 * 8);
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_std_reset();
    t_od_reset();
    t_std_write();
    t_od_write();
    t_reads();
    t_speed_latch();
    t_busy_ignore();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule